// File: doc/BRIEF.md
# Single-Cycle RV32I Control Decoder

This block is the purely combinational control unit of a single-cycle RV32I datapath. It looks at the fetched instruction word together with the two flags from the branch comparator (operands equal, operand A less than operand B). From these it produces every select and enable the datapath needs for that cycle: where the next PC comes from, which immediate format to build, whether the comparison is unsigned, the two ALU operand sources, the ALU operation, the data-memory direction, the register-file write enable and the write-back source.

Only nine instruction bits identify the instruction class: bit 30, the funct3 field (bits 14:12) and opcode bits 6:2. With the two comparator flags these form an 11-bit key. The key maps to a 15-bit control word. Branch-taken is resolved inside the decoder, so the next-PC select is final and needs no further gating. A parameter picks one of two builds: a 512-entry class table filled at elaboration, or plain decode logic. Both produce the same word. Any class outside the supported subset produces an all-zero word. That word writes neither the register file nor memory and lets the PC advance by 4.

Top module: `rv_ctrl_decoder`

## Requirements
- R1: Outputs depend only on instr bits 30, 14:12 and 6:2 and on the two comparator flags; every other instruction bit has no effect on any output.
- R2: Register-register class (opcode bits 6:2 = 01100) is valid for any funct3 when bit 30 is 0, and for funct3 000 or 101 when bit 30 is 1. It gives alu_op = {bit30, funct3}, reg_we = 1, wb_sel = 1 (ALU result), and 0 in every other field.
- R3: Register-immediate class (01100 becomes 00100) gives imm_sel = 0 (I), b_sel = 1 (immediate), reg_we = 1 and wb_sel = 1. alu_op is {bit30, 101} for funct3 101 and {0, funct3} otherwise. funct3 001 with bit 30 set is unsupported.
- R4: Load class (00000) with funct3 000, 001, 010, 100 or 101 gives imm_sel = 0, b_sel = 1, alu_op = 0000 (add), reg_we = 1 and wb_sel = 0 (memory data). Other funct3 values are unsupported.
- R5: Store class (01000) with funct3 000 to 010 gives imm_sel = 1 (S), b_sel = 1, alu_op = 0000, mem_write = 1 and reg_we = 0.
- R6: Branch class (11000) with funct3 other than 010/011 gives imm_sel = 2 (B), a_sel = 1 (PC), b_sel = 1, alu_op = 0000 and reg_we = 0. cmp_unsigned equals funct3 bit 1.
- R7: A branch sets pc_sel = 1 (ALU target) exactly when it is taken: funct3 000 on equal, 001 on not equal, 100/110 on less-than, 101/111 on not less-than.
- R8: Indirect jump class (11001) with funct3 000 gives imm_sel = 0, b_sel = 1, alu_op = 0000, reg_we = 1, wb_sel = 2 (PC+4) and pc_sel = 1, whatever the flags.
- R9: Direct jump class (11011) gives imm_sel = 4 (J), a_sel = 1, b_sel = 1, alu_op = 0000, reg_we = 1, wb_sel = 2 and pc_sel = 1.
- R10: PC-relative upper class (00101) gives imm_sel = 3 (U), a_sel = 1, b_sel = 1, alu_op = 0000, reg_we = 1 and wb_sel = 1. Load-upper class (01101) gives imm_sel = 3, b_sel = 1, alu_op = 1111 (pass operand B), reg_we = 1 and wb_sel = 1.
- R11: Any unsupported class drives every output to 0: pc_sel = 0 (PC+4), mem_write = 0 (read), reg_we = 0. Fields that R2 to R10 do not name are also 0.
- R12: The table build (TABLE_BUILD = 1) and the logic build (TABLE_BUILD = 0) produce identical outputs for every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Fetched instruction word |
| cmp_eq_i | input | 1 | Comparator: operands equal |
| cmp_lt_i | input | 1 | Comparator: operand A less than operand B |
| pc_sel_o | output | 1 | Next PC: 0 = PC+4, 1 = ALU result |
| imm_sel_o | output | 3 | Immediate format: 0 I, 1 S, 2 B, 3 U, 4 J |
| cmp_unsigned_o | output | 1 | Comparator runs unsigned |
| a_sel_o | output | 1 | ALU operand A: 0 = register, 1 = PC |
| b_sel_o | output | 1 | ALU operand B: 0 = register, 1 = immediate |
| alu_op_o | output | 4 | ALU operation code |
| mem_write_o | output | 1 | Data memory: 0 = read, 1 = write |
| reg_we_o | output | 1 | Register-file write enable |
| wb_sel_o | output | 2 | Write-back: 0 memory, 1 ALU, 2 PC+4 |

## Verification
The bench sweeps all 2048 values of the 11-bit key and fills the unused instruction bits at random. This covers every supported class, every illegal funct3 slot and every flag combination against one reference table. A branch key therefore shows up with all four flag pairs, which separates taken from not-taken for each condition and separates signed from unsigned compare. Further random fills of the same key check that the ignored bits really change nothing. Both builds are compared against that reference side by side, which separates a table-indexing fault from a decode-logic fault.

// File: rtl/rv_ctrl_pkg.sv
package rv_ctrl_pkg;

    localparam int OPC_W   = 5;
    localparam int F3_W    = 3;
    localparam int CLASS_W = 1 + F3_W + OPC_W;
    localparam int KEY_W   = CLASS_W + 2;
    localparam int ALU_W   = 4;
    localparam int CLASS_DEPTH = 1 << CLASS_W;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 5'b00000;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 5'b00100;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 5'b00101;
    localparam logic [OPC_W-1:0] OPC_STORE  = 5'b01000;
    localparam logic [OPC_W-1:0] OPC_OPREG  = 5'b01100;
    localparam logic [OPC_W-1:0] OPC_LUI    = 5'b01101;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 5'b11000;
    localparam logic [OPC_W-1:0] OPC_JALR   = 5'b11001;
    localparam logic [OPC_W-1:0] OPC_JAL    = 5'b11011;

    localparam logic [ALU_W-1:0] ALU_ADD    = 4'b0000;
    localparam logic [ALU_W-1:0] ALU_PASS_B = 4'b1111;

    typedef enum logic [2:0] {
        IMM_I = 3'd0,
        IMM_S = 3'd1,
        IMM_B = 3'd2,
        IMM_U = 3'd3,
        IMM_J = 3'd4
    } imm_kind_e;

    typedef enum logic [1:0] {
        WB_MEM  = 2'd0,
        WB_ALU  = 2'd1,
        WB_LINK = 2'd2
    } wb_src_e;

    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_JUMP = 3'd1,
        FLOW_EQ   = 3'd2,
        FLOW_NE   = 3'd3,
        FLOW_LT   = 3'd4,
        FLOW_GE   = 3'd5
    } flow_e;

    // Field order of the 15-bit control word, most significant first.
    typedef struct packed {
        logic             pc_alu;
        imm_kind_e        imm;
        logic             cmp_uns;
        logic             a_pc;
        logic             b_imm;
        logic [ALU_W-1:0] alu;
        logic             mem_wr;
        logic             reg_we;
        wb_src_e          wb;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
        flow_e flow;
    } class_row_t;

    // Class decode: {bit30, funct3, opcode[6:2]} -> control row.
    // pc_alu is left 0 here; the flow resolver owns the next-PC choice.
    function automatic class_row_t decode_class(input logic [CLASS_W-1:0] cls);
        class_row_t       r;
        logic [OPC_W-1:0] op;
        logic [F3_W-1:0]  f3;
        logic             b30;
        op  = cls[OPC_W-1:0];
        f3  = cls[OPC_W +: F3_W];
        b30 = cls[CLASS_W-1];
        r   = '0;
        unique case (op)
            OPC_OPREG: begin
                if (!b30 || f3 == 3'b000 || f3 == 3'b101) begin
                    r.ctrl.alu    = {b30, f3};
                    r.ctrl.reg_we = 1'b1;
                    r.ctrl.wb     = WB_ALU;
                end
            end
            OPC_OPIMM: begin
                if (!(b30 && f3 == 3'b001)) begin
                    r.ctrl.imm    = IMM_I;
                    r.ctrl.b_imm  = 1'b1;
                    r.ctrl.alu    = (f3 == 3'b101) ? {b30, f3} : {1'b0, f3};
                    r.ctrl.reg_we = 1'b1;
                    r.ctrl.wb     = WB_ALU;
                end
            end
            OPC_LOAD: begin
                if (f3 != 3'b011 && f3[2:1] != 2'b11) begin
                    r.ctrl.imm    = IMM_I;
                    r.ctrl.b_imm  = 1'b1;
                    r.ctrl.alu    = ALU_ADD;
                    r.ctrl.reg_we = 1'b1;
                    r.ctrl.wb     = WB_MEM;
                end
            end
            OPC_STORE: begin
                if (f3 < 3'b011) begin
                    r.ctrl.imm    = IMM_S;
                    r.ctrl.b_imm  = 1'b1;
                    r.ctrl.alu    = ALU_ADD;
                    r.ctrl.mem_wr = 1'b1;
                end
            end
            OPC_BRANCH: begin
                if (f3[2:1] != 2'b01) begin
                    r.ctrl.imm     = IMM_B;
                    r.ctrl.a_pc    = 1'b1;
                    r.ctrl.b_imm   = 1'b1;
                    r.ctrl.alu     = ALU_ADD;
                    r.ctrl.cmp_uns = f3[1];
                    if (!f3[2]) r.flow = f3[0] ? FLOW_NE : FLOW_EQ;
                    else        r.flow = f3[0] ? FLOW_GE : FLOW_LT;
                end
            end
            OPC_JALR: begin
                if (f3 == 3'b000) begin
                    r.ctrl.imm    = IMM_I;
                    r.ctrl.b_imm  = 1'b1;
                    r.ctrl.alu    = ALU_ADD;
                    r.ctrl.reg_we = 1'b1;
                    r.ctrl.wb     = WB_LINK;
                    r.flow        = FLOW_JUMP;
                end
            end
            OPC_JAL: begin
                r.ctrl.imm    = IMM_J;
                r.ctrl.a_pc   = 1'b1;
                r.ctrl.b_imm  = 1'b1;
                r.ctrl.alu    = ALU_ADD;
                r.ctrl.reg_we = 1'b1;
                r.ctrl.wb     = WB_LINK;
                r.flow        = FLOW_JUMP;
            end
            OPC_AUIPC: begin
                r.ctrl.imm    = IMM_U;
                r.ctrl.a_pc   = 1'b1;
                r.ctrl.b_imm  = 1'b1;
                r.ctrl.alu    = ALU_ADD;
                r.ctrl.reg_we = 1'b1;
                r.ctrl.wb     = WB_ALU;
            end
            OPC_LUI: begin
                r.ctrl.imm    = IMM_U;
                r.ctrl.b_imm  = 1'b1;
                r.ctrl.alu    = ALU_PASS_B;
                r.ctrl.reg_we = 1'b1;
                r.ctrl.wb     = WB_ALU;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rv_ctrl_key.sv
module rv_ctrl_key
    import rv_ctrl_pkg::*;
(
    input  logic [31:0]        instr_i,
    input  logic               cmp_eq_i,
    input  logic               cmp_lt_i,
    output logic [CLASS_W-1:0] class_o,
    output logic [KEY_W-1:0]   key_o
);
    logic unused_instr_bits;

    assign class_o = {instr_i[30], instr_i[14:12], instr_i[6:2]};
    assign key_o   = {class_o, cmp_eq_i, cmp_lt_i};
    assign unused_instr_bits = ^{instr_i[31], instr_i[29:15], instr_i[11:7], instr_i[1:0]};
endmodule

// File: rtl/rv_ctrl_class_table.sv
module rv_ctrl_class_table
    import rv_ctrl_pkg::*;
#(
    parameter bit TABLE_BUILD = 1'b0
) (
    input  logic [CLASS_W-1:0] class_i,
    output class_row_t         row_o
);
    generate
        if (TABLE_BUILD) begin : g_table
            class_row_t rows [CLASS_DEPTH];
            for (genvar g = 0; g < CLASS_DEPTH; g++) begin : g_row
                assign rows[g] = decode_class(CLASS_W'(g));
            end
            assign row_o = rows[class_i];
        end else begin : g_logic
            assign row_o = decode_class(class_i);
        end
    endgenerate
endmodule

// File: rtl/rv_ctrl_flow.sv
module rv_ctrl_flow
    import rv_ctrl_pkg::*;
(
    input  flow_e flow_i,
    input  logic  cmp_eq_i,
    input  logic  cmp_lt_i,
    output logic  take_o
);
    always_comb begin
        unique case (flow_i)
            FLOW_JUMP: take_o = 1'b1;
            FLOW_EQ:   take_o = cmp_eq_i;
            FLOW_NE:   take_o = ~cmp_eq_i;
            FLOW_LT:   take_o = cmp_lt_i;
            FLOW_GE:   take_o = ~cmp_lt_i;
            default:   take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rv_ctrl_decoder.sv
module rv_ctrl_decoder
    import rv_ctrl_pkg::*;
#(
    parameter bit TABLE_BUILD = 1'b0
) (
    input  logic [31:0] instr_i,
    input  logic        cmp_eq_i,
    input  logic        cmp_lt_i,
    output logic        pc_sel_o,
    output logic [2:0]  imm_sel_o,
    output logic        cmp_unsigned_o,
    output logic        a_sel_o,
    output logic        b_sel_o,
    output logic [3:0]  alu_op_o,
    output logic        mem_write_o,
    output logic        reg_we_o,
    output logic [1:0]  wb_sel_o
);
    logic [CLASS_W-1:0] cls;
    logic [KEY_W-1:0]   key;
    logic               eq_k;
    logic               lt_k;
    class_row_t         row;
    logic               take;
    ctrl_t              word;

    rv_ctrl_key u_key (
        .instr_i  (instr_i),
        .cmp_eq_i (cmp_eq_i),
        .cmp_lt_i (cmp_lt_i),
        .class_o  (cls),
        .key_o    (key)
    );

    assign eq_k = key[1];
    assign lt_k = key[0];

    rv_ctrl_class_table #(.TABLE_BUILD(TABLE_BUILD)) u_table (
        .class_i (cls),
        .row_o   (row)
    );

    rv_ctrl_flow u_flow (
        .flow_i   (row.flow),
        .cmp_eq_i (eq_k),
        .cmp_lt_i (lt_k),
        .take_o   (take)
    );

    always_comb begin
        word        = row.ctrl;
        word.pc_alu = take;
    end

    assign pc_sel_o       = word.pc_alu;
    assign imm_sel_o      = word.imm;
    assign cmp_unsigned_o = word.cmp_uns;
    assign a_sel_o        = word.a_pc;
    assign b_sel_o        = word.b_imm;
    assign alu_op_o       = word.alu;
    assign mem_write_o    = word.mem_wr;
    assign reg_we_o       = word.reg_we;
    assign wb_sel_o       = word.wb;
endmodule

// File: rtl/rv_ctrl_decoder_chk.sv
module rv_ctrl_decoder_chk (
    input logic [4:0] op_i,
    input logic       pc_sel_i,
    input logic       cmp_unsigned_i,
    input logic       mem_write_i,
    input logic       reg_we_i,
    input logic [1:0] wb_sel_i
);
    always_comb begin
        if (!$isunknown({op_i, pc_sel_i, cmp_unsigned_i, mem_write_i, reg_we_i, wb_sel_i})) begin
            a_r5_store_no_regwrite: assert (!(mem_write_i && reg_we_i))
                else $error("store also writes register");
            a_r5_store_opcode: assert (!mem_write_i || op_i == 5'b01000)
                else $error("memory write outside store class");
            a_r6_unsigned_branch_only: assert (!cmp_unsigned_i || op_i == 5'b11000)
                else $error("unsigned compare outside branch class");
            a_r7_redirect_no_write: assert (!(pc_sel_i && !reg_we_i) || op_i == 5'b11000)
                else $error("silent redirect outside branch class");
            a_r8_link_redirects: assert (!(wb_sel_i == 2'd2) || (pc_sel_i && reg_we_i))
                else $error("link write-back without jump");
            a_r4_memdata_load_only: assert (!(reg_we_i && wb_sel_i == 2'd0) || op_i == 5'b00000)
                else $error("memory write-back outside load class");
            a_r11_wb_code_legal: assert (wb_sel_i != 2'd3)
                else $error("illegal write-back code");
        end
    end
endmodule

bind rv_ctrl_decoder rv_ctrl_decoder_chk u_chk (
    .op_i           (instr_i[6:2]),
    .pc_sel_i       (pc_sel_o),
    .cmp_unsigned_i (cmp_unsigned_o),
    .mem_write_i    (mem_write_o),
    .reg_we_i       (reg_we_o),
    .wb_sel_i       (wb_sel_o)
);

// File: tb/rv_ctrl_decoder_bench.sv
module rv_ctrl_decoder_bench;

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic        eq = 1'b0;
    logic        lt = 1'b0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    logic        pc_a, un_a, as_a, bs_a, mw_a, we_a;
    logic [2:0]  im_a;
    logic [3:0]  al_a;
    logic [1:0]  wb_a;
    logic        pc_b, un_b, as_b, bs_b, mw_b, we_b;
    logic [2:0]  im_b;
    logic [3:0]  al_b;
    logic [1:0]  wb_b;

    always #4 clk = ~clk;

    rv_ctrl_decoder #(.TABLE_BUILD(1'b0)) u_rv_ctrl_decoder (
        .instr_i(instr), .cmp_eq_i(eq), .cmp_lt_i(lt),
        .pc_sel_o(pc_a), .imm_sel_o(im_a), .cmp_unsigned_o(un_a),
        .a_sel_o(as_a), .b_sel_o(bs_a), .alu_op_o(al_a),
        .mem_write_o(mw_a), .reg_we_o(we_a), .wb_sel_o(wb_a)
    );

    rv_ctrl_decoder #(.TABLE_BUILD(1'b1)) u_rv_ctrl_decoder_tbl (
        .instr_i(instr), .cmp_eq_i(eq), .cmp_lt_i(lt),
        .pc_sel_o(pc_b), .imm_sel_o(im_b), .cmp_unsigned_o(un_b),
        .a_sel_o(as_b), .b_sel_o(bs_b), .alu_op_o(al_b),
        .mem_write_o(mw_b), .reg_we_o(we_b), .wb_sel_o(wb_b)
    );

    // Reference word {pc, imm3, uns, a, b, alu4, mw, we, wb2} from key {b30, f3, op5, eq, lt}.
    function automatic logic [14:0] ref_word(input logic [10:0] k);
        logic       b30, e, l, pc, un, a, b, mw, we;
        logic [2:0] f3, im;
        logic [4:0] op;
        logic [3:0] al;
        logic [1:0] wb;
        b30 = k[10]; f3 = k[9:7]; op = k[6:2]; e = k[1]; l = k[0];
        pc = 0; im = 0; un = 0; a = 0; b = 0; al = 0; mw = 0; we = 0; wb = 0;
        if (op == 5'b01100 && (!b30 || f3 == 3'd0 || f3 == 3'd5)) begin
            al = {b30, f3}; we = 1; wb = 1;
        end else if (op == 5'b00100 && !(f3 == 3'd1 && b30)) begin
            b = 1; we = 1; wb = 1; al = (f3 == 3'd5) ? {b30, 3'd5} : {1'b0, f3};
        end else if (op == 5'b00000 && (f3 == 0 || f3 == 1 || f3 == 2 || f3 == 4 || f3 == 5)) begin
            b = 1; we = 1; wb = 0;
        end else if (op == 5'b01000 && f3 <= 3'd2) begin
            im = 1; b = 1; mw = 1;
        end else if (op == 5'b11000 && f3 != 3'd2 && f3 != 3'd3) begin
            im = 2; a = 1; b = 1; un = (f3 >= 3'd6);
            case (f3)
                3'd0:       pc = e;
                3'd1:       pc = !e;
                3'd4, 3'd6: pc = l;
                default:    pc = !l;
            endcase
        end else if (op == 5'b11001 && f3 == 3'd0) begin
            b = 1; we = 1; wb = 2; pc = 1;
        end else if (op == 5'b11011) begin
            im = 4; a = 1; b = 1; we = 1; wb = 2; pc = 1;
        end else if (op == 5'b00101) begin
            im = 3; a = 1; b = 1; we = 1; wb = 1;
        end else if (op == 5'b01101) begin
            im = 3; b = 1; al = 4'hF; we = 1; wb = 1;
        end
        return {pc, im, un, a, b, al, mw, we, wb};
    endfunction

    function automatic string ref_req(input logic [10:0] k);
        logic [14:0] w;
        w = ref_word(k);
        if (w == '0) return "R11";
        case (k[6:2])
            5'b01100: return "R2";
            5'b00100: return "R3";
            5'b00000: return "R4";
            5'b01000: return "R5";
            5'b11000: return "R6 R7";
            5'b11001: return "R8";
            5'b11011: return "R9";
            default:  return "R10";
        endcase
    endfunction

    function automatic logic [31:0] build_instr(input logic [10:0] k, input logic [31:0] fill);
        logic [31:0] v;
        v = fill;
        v[30] = k[10];
        v[14:12] = k[9:7];
        v[6:2] = k[6:2];
        return v;
    endfunction

    task automatic check(input logic [14:0] got, input logic [14:0] exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply_and_check(input logic [10:0] k, input logic [31:0] fill, input string extra);
        logic [14:0] exp;
        @(negedge clk);
        instr = build_instr(k, fill);
        eq = k[1];
        lt = k[0];
        #1;
        exp = ref_word(k);
        check({pc_a, im_a, un_a, as_a, bs_a, al_a, mw_a, we_a, wb_a}, exp, ref_req(k),
              $sformatf("logic build key=%h %s", k, extra));
        check({pc_b, im_b, un_b, as_b, bs_b, al_b, mw_b, we_b, wb_b}, exp,
              $sformatf("R12 %s", ref_req(k)), $sformatf("table build key=%h %s", k, extra));
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_C0DE);
        // Directed corners: all-zero word (byte load), all-ones word (unsupported, R11),
        // taken/not-taken signed and unsigned branches (R7), jumps ignoring flags (R8, R9).
        apply_and_check(11'h000, 32'h0000_0000, "zero word");
        apply_and_check(11'h7FF, 32'hFFFF_FFFF, "ones word");
        apply_and_check({1'b0, 3'd0, 5'b11000, 2'b10}, 32'h0, "beq taken");
        apply_and_check({1'b0, 3'd7, 5'b11000, 2'b01}, 32'h0, "bgeu not taken");
        apply_and_check({1'b0, 3'd0, 5'b11001, 2'b00}, 32'h0, "jalr flags low");
        apply_and_check({1'b1, 3'd5, 5'b11011, 2'b11}, 32'h0, "jal flags high");
        // Full sweep of the 11-bit key with random filler bits.
        for (int k = 0; k < 2048; k++) begin
            apply_and_check(11'(k), $urandom, "sweep");
        end
        // R1: same key, different filler bits, must give the same word.
        for (int i = 0; i < 200; i++) begin
            logic [10:0] rk;
            rk = 11'($urandom);
            apply_and_check(rk, $urandom, "R1 fill A");
            apply_and_check(rk, ~$urandom, "R1 fill B");
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule